// File: doc/BRIEF.md
# Banked Register Access Decoder

This block decodes the banked forms of the move-to-register and move-from-register instructions of a 32-bit processor. These forms let privileged code read or write a register that belongs to a processor mode other than the current one. The block pulls the relevant fields out of the instruction word for either the fixed 32-bit encoding or the mixed 16/32-bit encoding. It maps the irregular (R, SYSm) selector pair onto a target mode and an internal register number. It then applies the feature, privilege and security checks that can be settled at decode time.

The outputs are purely combinational. A decode stage places the block beside its main decoder. When `undef` is high the instruction must raise an undefined-instruction fault, and `fault_el` names the exception level that takes it. When `undef` is low, `target_mode` and `target_reg` name the banked register for the execute stage. Checks that depend on the mode in force at run time, and the banked storage itself, belong to other blocks.

Top module: `bank_access_decoder`

## Requirements
- R1: With `mixed_form`=0, `banked_form`=insn[9], R=insn[22], SYSm={insn[8],insn[19:16]} and `xfer_write`=insn[21]. `xfer_reg` is insn[3:0] for a write and insn[15:12] for a read. With `mixed_form`=1, `banked_form`=insn[5], R=insn[20], SYSm={insn[4],insn[11:8]}, `xfer_write`=1 and `xfer_reg`=insn[19:16].
- R2: `undef` is 1, with `fault_el`=`default_el`, when both `feat_v8` and `feat_virt` are 0, when `user_mode`=1, or when `xfer_reg`=15.
- R3: With R=1, SYSm selects a saved status register with `target_reg`=16. The codes are 0x0E FIQ, 0x10 IRQ, 0x12 supervisor, 0x14 abort, 0x16 undefined, 0x1C monitor and 0x1E hypervisor. Every other SYSm value gives `undef`=1.
- R4: With R=0, SYSm 0x00 to 0x06 selects user-mode r8 to r14 (`target_reg`=SYSm+8). SYSm 0x08 to 0x0E selects FIQ-mode r8 to r14 (`target_reg`=SYSm).
- R5: With R=0, the pairs 0x10/0x11 IRQ, 0x12/0x13 supervisor, 0x14/0x15 abort, 0x16/0x17 undefined and 0x1C/0x1D monitor select r14 (`target_reg`=14) when SYSm bit 0 is 0. They select r13 (`target_reg`=13) when it is 1.
- R6: With R=0, SYSm 0x1E selects the hypervisor exception link register (`target_reg`=17) and 0x1F selects hypervisor r13. The values 0x07, 0x0F and 0x18 to 0x1B give `undef`=1.
- R7: A monitor target gives `undef`=1 with `fault_el`=`default_el` when `feat_secmon`=0 or `nonsecure`=1. Otherwise, when `cur_el`=1, it gives `undef`=1 with `fault_el`=3.
- R8: A hypervisor target gives `undef`=1 unless `feat_virt`=1 and `cur_el`=3.
- R9: `target_mode` uses the 5-bit codes user 0x10, FIQ 0x11, IRQ 0x12, supervisor 0x13, monitor 0x16, abort 0x17, hypervisor 0x1A and undefined 0x1B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_word | input | 32 | Instruction word being decoded |
| mixed_form | input | 1 | 1 selects the mixed 16/32-bit encoding (write form) |
| feat_v8 | input | 1 | Later architecture level present |
| feat_virt | input | 1 | Virtualization level present |
| feat_secmon | input | 1 | Secure-monitor level present |
| cur_el | input | 2 | Current exception level |
| default_el | input | 2 | Exception level that normally takes an undefined fault |
| nonsecure | input | 1 | Current state is non-secure |
| user_mode | input | 1 | Processor runs in unprivileged mode |
| banked_form | output | 1 | Instruction carries the banked-form marker |
| xfer_write | output | 1 | 1 for move-to-banked, 0 for move-from-banked |
| xfer_reg | output | 4 | Source or destination general register index |
| target_mode | output | 5 | Mode that owns the addressed register |
| target_reg | output | 5 | Internal register number (8 to 14, 16 status, 17 link) |
| undef | output | 1 | Instruction is undefined |
| fault_el | output | 2 | Exception level that takes the undefined fault |

## Verification
The hardest case to reach is the fault redirected to level 3. It needs a monitor selector in either the status or the general map, a present secure-monitor level, a secure state and a current level of 1. None of the earlier failures may apply: a missing feature, user mode or register 15. Uniform random words reach this only rarely. The stimulus therefore builds each instruction from chosen fields, biases the features on and user mode off, and adds directed vectors that pin every term of the redirect and then flip one term at a time.

// File: rtl/bank_decode_pkg.sv
package bank_decode_pkg;

    localparam int INSN_W   = 32;
    localparam int SYSM_W   = 5;
    localparam int MODE_W   = 5;
    localparam int REGNUM_W = 5;
    localparam int IDX_W    = 4;
    localparam int EL_W     = 2;
    localparam int PAIR_W   = SYSM_W - 2;

    // Bit positions of the fixed 32-bit encoding
    localparam int FX_MARK_BIT  = 9;
    localparam int FX_R_BIT     = 22;
    localparam int FX_HI_BIT    = 8;
    localparam int FX_LO_POS    = 16;
    localparam int FX_WR_BIT    = 21;
    localparam int FX_SRC_POS   = 0;
    localparam int FX_DST_POS   = 12;

    // Bit positions of the mixed 16/32-bit encoding (write form)
    localparam int MX_MARK_BIT  = 5;
    localparam int MX_R_BIT     = 20;
    localparam int MX_HI_BIT    = 4;
    localparam int MX_LO_POS    = 8;
    localparam int MX_SRC_POS   = 16;

    localparam logic [MODE_W-1:0] MODE_USR = 5'h10;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
    localparam logic [MODE_W-1:0] MODE_MON = 5'h16;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
    localparam logic [MODE_W-1:0] MODE_HYP = 5'h1A;
    localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;
    localparam logic [MODE_W-1:0] MODE_SYS = 5'h1F;

    localparam logic [REGNUM_W-1:0] REG_SP     = 5'd13;
    localparam logic [REGNUM_W-1:0] REG_LINK   = 5'd14;
    localparam logic [REGNUM_W-1:0] REG_STATUS = 5'd16;
    localparam logic [REGNUM_W-1:0] REG_HLINK  = 5'd17;
    localparam logic [IDX_W-1:0]    IDX_PC     = 4'd15;
    localparam logic [EL_W-1:0]     EL_TOP     = 2'd3;
    localparam logic [EL_W-1:0]     EL_ONE     = 2'd1;

    typedef struct packed {
        logic              banked;
        logic              is_write;
        logic              r_sel;
        logic [SYSM_W-1:0] sysm;
        logic [IDX_W-1:0]  reg_idx;
    } bank_fields_t;

    typedef struct packed {
        logic                ok;
        logic [MODE_W-1:0]   mode;
    } pair_lookup_t;

    typedef struct packed {
        logic                unalloc;
        logic [MODE_W-1:0]   mode;
        logic [REGNUM_W-1:0] regnum;
    } bank_target_t;

    typedef struct packed {
        logic            undef;
        logic [EL_W-1:0] fault_el;
    } bank_verdict_t;

    // Upper half of the selector space: each pair of codes shares one mode
    function automatic pair_lookup_t pair_lookup(input logic [PAIR_W-1:0] pair);
        pair_lookup_t res;
        res.ok   = 1'b1;
        res.mode = MODE_USR;
        case (pair)
            3'd0:    res.mode = MODE_IRQ;
            3'd1:    res.mode = MODE_SVC;
            3'd2:    res.mode = MODE_ABT;
            3'd3:    res.mode = MODE_UND;
            3'd6:    res.mode = MODE_MON;
            3'd7:    res.mode = MODE_HYP;
            default: res.ok   = 1'b0;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/bank_field_extract.sv
module bank_field_extract
    import bank_decode_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    input  logic              mixed_form,
    output bank_fields_t      fields
);

    bank_fields_t fields_d;

    always_comb begin
        fields_d = '0;
        if (mixed_form) begin
            fields_d.banked   = insn[MX_MARK_BIT];
            fields_d.r_sel    = insn[MX_R_BIT];
            fields_d.sysm     = {insn[MX_HI_BIT], insn[MX_LO_POS +: SYSM_W-1]};
            fields_d.is_write = 1'b1;
            fields_d.reg_idx  = insn[MX_SRC_POS +: IDX_W];
        end else begin
            fields_d.banked   = insn[FX_MARK_BIT];
            fields_d.r_sel    = insn[FX_R_BIT];
            fields_d.sysm     = {insn[FX_HI_BIT], insn[FX_LO_POS +: SYSM_W-1]};
            fields_d.is_write = insn[FX_WR_BIT];
            fields_d.reg_idx  = insn[FX_WR_BIT] ? insn[FX_SRC_POS +: IDX_W]
                                                : insn[FX_DST_POS +: IDX_W];
        end
    end

    assign fields = fields_d;

endmodule

// File: rtl/bank_target_map.sv
module bank_target_map
    import bank_decode_pkg::*;
(
    input  logic              r_sel,
    input  logic [SYSM_W-1:0] sysm,
    output bank_target_t      target
);

    localparam logic [SYSM_W-1:0] SYSM_FIQ_STATUS = 5'h0E;

    bank_target_t target_d;
    pair_lookup_t pair;

    always_comb begin
        pair              = pair_lookup(sysm[SYSM_W-2:1]);
        target_d.unalloc  = 1'b1;
        target_d.mode     = MODE_USR;
        target_d.regnum   = '0;
        if (r_sel) begin
            // saved status registers: even codes only
            if (sysm == SYSM_FIQ_STATUS) begin
                target_d.unalloc = 1'b0;
                target_d.mode    = MODE_FIQ;
                target_d.regnum  = REG_STATUS;
            end else if (sysm[SYSM_W-1] && !sysm[0] && pair.ok) begin
                target_d.unalloc = 1'b0;
                target_d.mode    = pair.mode;
                target_d.regnum  = REG_STATUS;
            end
        end else if (!sysm[SYSM_W-1]) begin
            // lower half: r8..r14 of user or FIQ mode, slot 7 unused
            if (sysm[2:0] != 3'b111) begin
                target_d.unalloc = 1'b0;
                target_d.mode    = sysm[3] ? MODE_FIQ : MODE_USR;
                target_d.regnum  = {2'b01, sysm[2:0]};
            end
        end else if (pair.ok) begin
            target_d.unalloc = 1'b0;
            target_d.mode    = pair.mode;
            if (sysm[0])
                target_d.regnum = REG_SP;
            else if (pair.mode == MODE_HYP)
                target_d.regnum = REG_HLINK;
            else
                target_d.regnum = REG_LINK;
        end
    end

    assign target = target_d;

endmodule

// File: rtl/bank_access_gate.sv
module bank_access_gate
    import bank_decode_pkg::*;
(
    input  bank_target_t      target,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic              feat_v8,
    input  logic              feat_virt,
    input  logic              feat_secmon,
    input  logic [EL_W-1:0]   cur_el,
    input  logic [EL_W-1:0]   default_el,
    input  logic              nonsecure,
    input  logic              user_mode,
    output bank_verdict_t     verdict
);

    bank_verdict_t verdict_d;
    logic          base_fail;
    logic          mon_tgt;
    logic          hyp_tgt;
    logic          mon_fail;
    logic          mon_trap;
    logic          hyp_fail;

    always_comb begin
        base_fail = !(feat_v8 || feat_virt) || user_mode ||
                    (reg_idx == IDX_PC) || target.unalloc;
        mon_tgt   = !target.unalloc && (target.mode == MODE_MON);
        hyp_tgt   = !target.unalloc && (target.mode == MODE_HYP);
        mon_fail  = mon_tgt && (!feat_secmon || nonsecure);
        mon_trap  = mon_tgt && !mon_fail && (cur_el == EL_ONE);
        hyp_fail  = hyp_tgt && (!feat_virt || (cur_el != EL_TOP));

        verdict_d.undef    = base_fail || mon_fail || mon_trap || hyp_fail;
        verdict_d.fault_el = (!base_fail && mon_trap) ? EL_TOP : default_el;
    end

    assign verdict = verdict_d;

endmodule

// File: rtl/bank_access_decoder.sv
module bank_access_decoder
    import bank_decode_pkg::*;
(
    input  logic [INSN_W-1:0]   insn_word,
    input  logic                mixed_form,
    input  logic                feat_v8,
    input  logic                feat_virt,
    input  logic                feat_secmon,
    input  logic [EL_W-1:0]     cur_el,
    input  logic [EL_W-1:0]     default_el,
    input  logic                nonsecure,
    input  logic                user_mode,
    output logic                banked_form,
    output logic                xfer_write,
    output logic [IDX_W-1:0]    xfer_reg,
    output logic [MODE_W-1:0]   target_mode,
    output logic [REGNUM_W-1:0] target_reg,
    output logic                undef,
    output logic [EL_W-1:0]     fault_el
);

    bank_fields_t  fields;
    bank_target_t  target;
    bank_verdict_t verdict;

    bank_field_extract u_extract (
        .insn       (insn_word),
        .mixed_form (mixed_form),
        .fields     (fields)
    );

    bank_target_map u_map (
        .r_sel  (fields.r_sel),
        .sysm   (fields.sysm),
        .target (target)
    );

    bank_access_gate u_gate (
        .target      (target),
        .reg_idx     (fields.reg_idx),
        .feat_v8     (feat_v8),
        .feat_virt   (feat_virt),
        .feat_secmon (feat_secmon),
        .cur_el      (cur_el),
        .default_el  (default_el),
        .nonsecure   (nonsecure),
        .user_mode   (user_mode),
        .verdict     (verdict)
    );

    assign banked_form = fields.banked;
    assign xfer_write  = fields.is_write;
    assign xfer_reg    = fields.reg_idx;
    assign target_mode = target.mode;
    assign target_reg  = target.regnum;
    assign undef       = verdict.undef;
    assign fault_el    = verdict.fault_el;

endmodule

// File: rtl/bank_access_checker.sv
module bank_access_checker
    import bank_decode_pkg::*;
(
    input logic                mixed_form,
    input logic                feat_v8,
    input logic                feat_virt,
    input logic                feat_secmon,
    input logic [EL_W-1:0]     cur_el,
    input logic [EL_W-1:0]     default_el,
    input logic                nonsecure,
    input logic                user_mode,
    input logic                xfer_write,
    input logic [IDX_W-1:0]    xfer_reg,
    input logic [MODE_W-1:0]   target_mode,
    input logic [REGNUM_W-1:0] target_reg,
    input logic                undef,
    input logic [EL_W-1:0]     fault_el
);

    logic known;

    always_comb begin
        known = !$isunknown({mixed_form, feat_v8, feat_virt, feat_secmon, cur_el,
                             default_el, nonsecure, user_mode, xfer_write,
                             xfer_reg, target_mode, target_reg, undef, fault_el});
        if (known) begin
            // R1
            mixed_write_chk: assert (!mixed_form || xfer_write);
            // R2
            user_blocks_chk: assert (!user_mode || undef);
            // R2
            pc_index_chk: assert (xfer_reg != IDX_PC || undef);
            // R2
            feature_gate_chk: assert (feat_v8 || feat_virt || undef);
            // R7
            mon_access_chk: assert (undef || target_mode != MODE_MON ||
                                    (feat_secmon && !nonsecure && cur_el != EL_ONE));
            // R7
            redirect_chk: assert (fault_el == default_el ||
                                  (undef && fault_el == EL_TOP && cur_el == EL_ONE));
            // R8
            hyp_access_chk: assert (undef || target_mode != MODE_HYP ||
                                    (feat_virt && cur_el == EL_TOP));
            // R3
            regnum_range_chk: assert (undef || (target_reg >= 5'd8 && target_reg <= REG_HLINK &&
                                                target_reg != 5'd15));
        end
    end

endmodule

bind bank_access_decoder bank_access_checker i_bank_access_checker (
    .mixed_form  (mixed_form),
    .feat_v8     (feat_v8),
    .feat_virt   (feat_virt),
    .feat_secmon (feat_secmon),
    .cur_el      (cur_el),
    .default_el  (default_el),
    .nonsecure   (nonsecure),
    .user_mode   (user_mode),
    .xfer_write  (xfer_write),
    .xfer_reg    (xfer_reg),
    .target_mode (target_mode),
    .target_reg  (target_reg),
    .undef       (undef),
    .fault_el    (fault_el)
);

// File: tb/test_bank_access_decoder.sv
module test_bank_access_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] insn_word = '0;
    logic        mixed_form = 1'b0;
    logic        feat_v8 = 1'b0, feat_virt = 1'b0, feat_secmon = 1'b0;
    logic [1:0]  cur_el = '0, default_el = '0;
    logic        nonsecure = 1'b0, user_mode = 1'b0;
    logic        banked_form, xfer_write, undef;
    logic [3:0]  xfer_reg;
    logic [4:0]  target_mode, target_reg;
    logic [1:0]  fault_el;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bank_access_decoder i_bank_access_decoder (
        .insn_word, .mixed_form, .feat_v8, .feat_virt, .feat_secmon,
        .cur_el, .default_el, .nonsecure, .user_mode,
        .banked_form, .xfer_write, .xfer_reg, .target_mode, .target_reg,
        .undef, .fault_el
    );

    // expected values
    logic       e_bank, e_wr, e_undef;
    logic [3:0] e_idx;
    logic [4:0] e_mode, e_reg;
    logic [1:0] e_el;
    string      e_tag;

    function automatic logic [4:0] pair_mode(input int p);
        case (p)
            8: return 5'h12; 9: return 5'h13; 10: return 5'h17;
            11: return 5'h1B; 14: return 5'h16; 15: return 5'h1A;
            default: return 5'h00;
        endcase
    endfunction

    task automatic model();
        logic r; logic [4:0] s; logic bad; logic trap;
        if (mixed_form) begin
            e_bank = insn_word[5]; r = insn_word[20];
            s = {insn_word[4], insn_word[11:8]};
            e_wr = 1'b1; e_idx = insn_word[19:16];
        end else begin
            e_bank = insn_word[9]; r = insn_word[22];
            s = {insn_word[8], insn_word[19:16]};
            e_wr = insn_word[21];
            e_idx = e_wr ? insn_word[3:0] : insn_word[15:12];
        end
        bad = 1'b0; e_mode = 5'h00; e_reg = 5'd0;
        if (r) begin
            e_tag = "R3"; e_reg = 5'd16;
            if (s == 5'h0E) e_mode = 5'h11;
            else if (s >= 5'h10 && s[0] == 1'b0 && pair_mode(int'(s >> 1)) != 5'h00)
                e_mode = pair_mode(int'(s >> 1));
            else bad = 1'b1;
        end else if (s <= 5'h06) begin
            e_tag = "R4"; e_mode = 5'h10; e_reg = s + 5'd8;
        end else if (s >= 5'h08 && s <= 5'h0E) begin
            e_tag = "R4"; e_mode = 5'h11; e_reg = s;
        end else if (s >= 5'h10 && pair_mode(int'(s >> 1)) != 5'h00) begin
            e_tag = (s >= 5'h1E) ? "R6" : "R5";
            e_mode = pair_mode(int'(s >> 1));
            e_reg = s[0] ? 5'd13 : ((s == 5'h1E) ? 5'd17 : 5'd14);
        end else begin
            e_tag = "R6"; bad = 1'b1;
        end
        trap = 1'b0;
        if (!(feat_v8 || feat_virt) || user_mode || e_idx == 4'd15) begin
            e_tag = "R2"; bad = 1'b1;
        end else if (!bad && e_mode == 5'h16) begin
            e_tag = "R7";
            if (!feat_secmon || nonsecure) bad = 1'b1;
            else if (cur_el == 2'd1) begin bad = 1'b1; trap = 1'b1; end
        end else if (!bad && e_mode == 5'h1A) begin
            e_tag = "R8";
            if (!feat_virt || cur_el != 2'd3) bad = 1'b1;
        end
        e_undef = bad;
        e_el = trap ? 2'd3 : default_el;
    endtask

    task automatic check_now(input string force_tag);
        string t;
        model();
        t = (force_tag != "") ? force_tag : e_tag;
        checks++;
        if (banked_form !== e_bank || xfer_write !== e_wr || xfer_reg !== e_idx) begin
            errors++;
            $display("FAIL R1 fields got %b/%b/%h exp %b/%b/%h",
                     banked_form, xfer_write, xfer_reg, e_bank, e_wr, e_idx);
        end
        checks++;
        if (undef !== e_undef || fault_el !== e_el ||
            (!e_undef && (target_mode !== e_mode || target_reg !== e_reg))) begin
            errors++;
            $display("FAIL %s insn=%h got undef=%b el=%0d mode=%h reg=%0d exp undef=%b el=%0d mode=%h reg=%0d",
                     t, insn_word, undef, fault_el, target_mode, target_reg,
                     e_undef, e_el, e_mode, e_reg);
        end
    endtask

    task automatic pack(input bit mx, input bit r, input logic [4:0] s,
                        input bit wr, input logic [3:0] idx);
        logic [31:0] w;
        w = $urandom;
        if (mx) begin
            w[5] = 1'b1; w[20] = r; w[4] = s[4]; w[11:8] = s[3:0]; w[19:16] = idx;
        end else begin
            w[9] = 1'b1; w[22] = r; w[8] = s[4]; w[19:16] = s[3:0]; w[21] = wr;
            if (wr) w[3:0] = idx; else w[15:12] = idx;
        end
        mixed_form = mx;
        insn_word = w;
    endtask

    task automatic ctx(input bit v8, input bit virt, input bit sm, input logic [1:0] el,
                       input logic [1:0] del, input bit ns, input bit usr);
        feat_v8 = v8; feat_virt = virt; feat_secmon = sm; cur_el = el;
        default_el = del; nonsecure = ns; user_mode = usr;
    endtask

    task automatic step(input string tag);
        @(negedge clk);
        #2;
        check_now(tag);
    endtask

    initial begin
        process::self().srandom(32'd1234);
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // quiet state after reset: all-zero inputs decode to an undefined access
        @(negedge clk); #2;
        checks++;
        if (undef !== 1'b1 || banked_form !== 1'b0) begin
            errors++;
            $display("FAIL R2 idle got undef=%b banked=%b exp 1/0", undef, banked_form);
        end

        // R9 mode codes: one valid access per mode, full privilege
        ctx(1, 1, 1, 2'd3, 2'd1, 0, 0);
        pack(0, 0, 5'h03, 1, 4'd2); step("R9");
        pack(0, 0, 5'h0C, 0, 4'd4); step("R9");
        pack(0, 1, 5'h10, 1, 4'd1); step("R9");
        pack(1, 1, 5'h12, 1, 4'd3); step("R9");
        pack(0, 0, 5'h15, 0, 4'd0); step("R9");
        pack(0, 0, 5'h17, 1, 4'd6); step("R9");
        pack(0, 1, 5'h1C, 1, 4'd7); step("R9");
        pack(0, 0, 5'h1E, 1, 4'd7); step("R6");
        pack(0, 0, 5'h1F, 0, 4'd8); step("R6");
        pack(1, 0, 5'h1D, 1, 4'd9); step("R5");
        // R6 holes
        pack(0, 0, 5'h07, 1, 4'd1); step("R6");
        pack(0, 0, 5'h0F, 1, 4'd1); step("R6");
        pack(0, 0, 5'h19, 1, 4'd1); step("R6");
        // R3 odd status selector and FIQ status
        pack(0, 1, 5'h11, 1, 4'd1); step("R3");
        pack(0, 1, 5'h0E, 0, 4'd1); step("R3");
        // R2 register 15 and user mode and missing features
        pack(0, 0, 5'h02, 1, 4'd15); step("R2");
        pack(1, 0, 5'h02, 1, 4'd15); step("R2");
        ctx(1, 1, 1, 2'd1, 2'd1, 0, 1);
        pack(0, 0, 5'h02, 1, 4'd3); step("R2");
        ctx(0, 0, 1, 2'd3, 2'd2, 0, 0);
        pack(0, 0, 5'h02, 1, 4'd3); step("R2");
        // R7 redirect and each blocking term
        ctx(1, 0, 1, 2'd1, 2'd1, 0, 0);
        pack(0, 1, 5'h1C, 1, 4'd3); step("R7");
        pack(0, 0, 5'h1D, 0, 4'd3); step("R7");
        ctx(1, 0, 1, 2'd1, 2'd2, 1, 0);
        pack(0, 0, 5'h1C, 1, 4'd3); step("R7");
        ctx(1, 0, 0, 2'd1, 2'd2, 0, 0);
        pack(0, 0, 5'h1C, 1, 4'd3); step("R7");
        ctx(1, 0, 1, 2'd3, 2'd2, 0, 0);
        pack(0, 0, 5'h1C, 1, 4'd3); step("R7");
        ctx(1, 0, 1, 2'd1, 2'd2, 0, 0);
        pack(0, 0, 5'h1C, 1, 4'd15); step("R7");
        // R8
        ctx(1, 0, 1, 2'd3, 2'd1, 0, 0);
        pack(0, 1, 5'h1E, 1, 4'd3); step("R8");
        ctx(1, 1, 1, 2'd2, 2'd1, 0, 0);
        pack(0, 0, 5'h1F, 1, 4'd3); step("R8");

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            ctx(($urandom % 8) != 0, ($urandom % 8) != 0, ($urandom % 8) != 0,
                2'($urandom), 2'($urandom), ($urandom % 2) == 1, ($urandom % 8) == 0);
            if ($urandom % 4 == 0) begin
                mixed_form = ($urandom % 2) == 1;
                insn_word = $urandom;
            end else begin
                pack(($urandom % 2) == 1, ($urandom % 2) == 1, 5'($urandom),
                     ($urandom % 2) == 1, ($urandom % 8 == 0) ? 4'd15 : 4'($urandom));
            end
            step("");
        end

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired got running exp finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    end

endmodule